// File: doc/BRIEF.md
# Edge-to-Edge Delay Measurement Unit

This block watches two single-bit inputs that are already synchronous to its sample clock: a reference clock and a response signal that the reference is expected to cause. For each selected edge of the reference it measures, in sample periods, how long the response takes to show its next selected edge. It reports that count with a one-cycle strobe. Which edge counts (rising, falling or both) is chosen separately for each input.

Edges that cannot be paired are counted. A second reference edge that arrives before a response is a missed reference. A response edge with no pending reference is a missed response. Each kind has a saturating counter and a one-cycle pulse. A two-state pairing machine handles a reference edge and a response edge that fall on the same sample. It never counts one edge twice. Timestamps come from a free-running counter, and the delay is taken modulo its width.

Top module: `edge_delay_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, all of the following are cleared: the strobe, the delay, both pulses, both counters and the pairing state. The state returns to waiting-for-reference. The stored previous samples of both inputs are also cleared to 0, so an input that is high at the first sample after reset counts as a rising edge.
- R2: Each input has a polarity code: 2'b00 selects rising edges, 2'b01 falling edges, 2'b10 both edges, and 2'b11 disables detection. An edge is a difference between the current sample and the stored previous sample.
- R3: The response edge that completes a pair is sampled at clock edge k+d, and the matching reference edge at clock edge k. One cycle later, `delay_vld_o` is high for one cycle and `delay_o` equals d.
- R4: The machine may be waiting for a reference when a reference edge and a response edge fall on the same sample. In that case the unit reports a delay of 0 for that sample and goes back to waiting for a reference.
- R5: The machine may be waiting for a response when both edges fall on the same sample. The unit then reports the pending delay and records this sample as the new reference time, and it counts no miss. The next response edge is measured from this sample.
- R6: A reference edge that arrives while a response is pending, with no response edge on that sample, raises `miss_ref_o` for one cycle and adds one to `miss_ref_cnt_o`. The reference time already stored is kept.
- R7: A response edge that arrives while no reference is pending, with no reference edge on that sample, raises `miss_resp_o` and adds one to `miss_resp_cnt_o`. This happens only if a pair has completed since reset. Before the first pair, such an edge has no effect.
- R8: The delay is computed modulo 2^TS_W, so one wrap of the timestamp counter between the two edges still gives the correct count.
- R9: Each miss counter stops at 2^MISS_W-1. Miss pulses are still raised after the counter has stopped.
- R10: `miss_clr_i` clears both miss counters at the next clock edge. The clear takes priority over an increment on the same edge.
- R11: Of `delay_vld_o`, `miss_ref_o` and `miss_resp_o`, at most one is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_i | input | 1 | Reference clock sample (synchronous) |
| resp_i | input | 1 | Response signal sample (synchronous) |
| ref_pol_i | input | 2 | Edge select for the reference |
| resp_pol_i | input | 2 | Edge select for the response |
| miss_clr_i | input | 1 | Synchronous clear of both miss counters |
| delay_o | output | TS_W | Measured delay in sample periods |
| delay_vld_o | output | 1 | One-cycle strobe for `delay_o` |
| miss_ref_o | output | 1 | One-cycle pulse on a missed reference edge |
| miss_resp_o | output | 1 | One-cycle pulse on a missed response edge |
| miss_ref_cnt_o | output | MISS_W | Saturating count of missed reference edges |
| miss_resp_cnt_o | output | MISS_W | Saturating count of missed response edges |

## Verification
The assertions assume that `ref_i` and `resp_i` change only between clock edges, and that both inputs are free of metastability. They also assume the polarity codes are stable around the edges they govern. The bench meets these assumptions by driving every input on the falling clock edge and sampling outputs one full cycle later. It changes polarity only while the inputs are idle. The measured delays are kept shorter than one wrap of the timestamp counter, because a longer gap cannot be told apart from a short one.

// File: rtl/edm_pkg.sv
// Package: shared encodings for the edge-to-edge delay measurement unit.
// Assumes nothing beyond 2-state-capable synthesis of enums.
package edm_pkg;

    // Edge-select code applied separately to each input.
    typedef enum logic [1:0] {
        POL_RISE = 2'b00,
        POL_FALL = 2'b01,
        POL_ANY  = 2'b10,
        POL_OFF  = 2'b11
    } pol_e;

    // Pairing machine state.
    typedef enum logic {
        ST_WAIT_REF  = 1'b0,
        ST_WAIT_RESP = 1'b1
    } pair_st_e;

endpackage

// File: rtl/edm_edge_detect.sv
// Module: edge detector for one synchronous input with selectable polarity.
// Keeps the previous sample (cleared to 0 in reset) and flags an edge in the
// same cycle as the sample that differs. Assumes lvl_i is already synchronous.
module edm_edge_detect
    import edm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic [1:0] pol_i,
    output logic       edge_o
);

    logic prev_q;

    // Purpose: hold the previous sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    // Purpose: decode the selected edge kind from current and previous sample.
    always_comb begin
        unique case (pol_e'(pol_i))
            POL_RISE: edge_o = lvl_i & ~prev_q;
            POL_FALL: edge_o = ~lvl_i & prev_q;
            POL_ANY:  edge_o = lvl_i ^ prev_q;
            default:  edge_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/edm_sat_counter.sv
// Module: saturating event counter with synchronous clear.
// Clear has priority over increment; the count holds at its maximum value.
module edm_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Purpose: count events, stop at the top, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_o <= '0;
        else if (clr_i)                    cnt_o <= '0;
        else if (inc_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> cnt_o == '0);                                    // R10
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == CNT_MAX && !clr_i) |=> cnt_o == CNT_MAX);        // R9

endmodule

// File: rtl/edm_pair_fsm.sv
// Module: two-state pairing machine. It pairs each reference edge with the
// next response edge and can take both steps within a single sample. It flags
// unpaired edges and does not count the same edge twice. Edges arrive
// combinationally from the detectors; now_i is the current sample timestamp.
module edm_pair_fsm
    import edm_pkg::*;
#(
    parameter int TS_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ref_edge_i,
    input  logic            resp_edge_i,
    input  logic [TS_W-1:0] now_i,
    output logic            deliver_o,
    output logic [TS_W-1:0] delay_o,
    output logic            miss_ref_o,
    output logic            miss_resp_o
);

    pair_st_e        st_q, st_n;
    logic [TS_W-1:0] ref_ts_q, ref_ts_n;
    logic            paired_q, paired_n;

    // Purpose: next-state and event decode for one sample, both steps allowed.
    always_comb begin
        st_n        = st_q;
        ref_ts_n    = ref_ts_q;
        paired_n    = paired_q;
        deliver_o   = 1'b0;
        miss_ref_o  = 1'b0;
        miss_resp_o = 1'b0;
        unique case (st_q)
            ST_WAIT_REF: begin
                if (ref_edge_i) begin
                    ref_ts_n = now_i;
                    if (resp_edge_i) begin
                        deliver_o = 1'b1;      // zero-delay pair, back to waiting
                        paired_n  = 1'b1;
                    end else begin
                        st_n = ST_WAIT_RESP;
                    end
                end else if (resp_edge_i && paired_q) begin
                    miss_resp_o = 1'b1;
                end
            end
            default: begin
                if (resp_edge_i) begin
                    deliver_o = 1'b1;
                    paired_n  = 1'b1;
                    if (ref_edge_i) ref_ts_n = now_i;   // re-arm on same sample
                    else            st_n     = ST_WAIT_REF;
                end else if (ref_edge_i) begin
                    miss_ref_o = 1'b1;
                end
            end
        endcase
    end

    // Purpose: delay of the pair completed in this sample, modulo 2^TS_W.
    always_comb begin
        delay_o = (st_q == ST_WAIT_RESP) ? (now_i - ref_ts_q) : '0;
    end

    // Purpose: state, reference timestamp and pairing-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_WAIT_REF;
            ref_ts_q <= '0;
            paired_q <= 1'b0;
        end else begin
            st_q     <= st_n;
            ref_ts_q <= ref_ts_n;
            paired_q <= paired_n;
        end
    end

    AST_ARM_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_REF && ref_edge_i && !resp_edge_i) |=> st_q == ST_WAIT_RESP); // R3
    AST_IDLE_WITHOUT_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT_REF && !ref_edge_i) |=> st_q == ST_WAIT_REF);                 // R7
    AST_KEEP_REF_TS: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ref_o |=> (st_q == ST_WAIT_RESP && $stable(ref_ts_q)));                   // R6

endmodule

// File: rtl/edge_delay_meter.sv
// Module: top of the edge-to-edge delay measurement unit. It contains the
// free-running timestamp counter, two edge detectors, the pairing machine,
// two saturating miss counters and the registered result outputs.
// Assumes ref_i and resp_i are already synchronous to clk.
module edge_delay_meter
    import edm_pkg::*;
#(
    parameter int TS_W   = 16,
    parameter int MISS_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_i,
    input  logic              resp_i,
    input  logic [1:0]        ref_pol_i,
    input  logic [1:0]        resp_pol_i,
    input  logic              miss_clr_i,
    output logic [TS_W-1:0]   delay_o,
    output logic              delay_vld_o,
    output logic              miss_ref_o,
    output logic              miss_resp_o,
    output logic [MISS_W-1:0] miss_ref_cnt_o,
    output logic [MISS_W-1:0] miss_resp_cnt_o
);

    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};
    localparam logic [MISS_W-1:0] MISS_ONE = MISS_W'(1);

    logic [TS_W-1:0] now_q;
    logic [TS_W-1:0] pair_delay;
    logic            ref_edge, resp_edge;
    logic            deliver, miss_ref_evt, miss_resp_evt;

    // Purpose: free-running sample timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) now_q <= '0;
        else        now_q <= now_q + 1'b1;
    end

    edm_edge_detect i_ref_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (ref_i),
        .pol_i  (ref_pol_i),
        .edge_o (ref_edge)
    );

    edm_edge_detect i_resp_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (resp_i),
        .pol_i  (resp_pol_i),
        .edge_o (resp_edge)
    );

    edm_pair_fsm #(.TS_W(TS_W)) i_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_edge_i  (ref_edge),
        .resp_edge_i (resp_edge),
        .now_i       (now_q),
        .deliver_o   (deliver),
        .delay_o     (pair_delay),
        .miss_ref_o  (miss_ref_evt),
        .miss_resp_o (miss_resp_evt)
    );

    edm_sat_counter #(.W(MISS_W)) i_ref_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (miss_clr_i),
        .inc_i (miss_ref_evt),
        .cnt_o (miss_ref_cnt_o)
    );

    edm_sat_counter #(.W(MISS_W)) i_resp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (miss_clr_i),
        .inc_i (miss_resp_evt),
        .cnt_o (miss_resp_cnt_o)
    );

    // Purpose: register the result strobe, delay and miss pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            delay_o     <= '0;
            delay_vld_o <= 1'b0;
            miss_ref_o  <= 1'b0;
            miss_resp_o <= 1'b0;
        end else begin
            delay_vld_o <= deliver;
            miss_ref_o  <= miss_ref_evt;
            miss_resp_o <= miss_resp_evt;
            if (deliver) delay_o <= pair_delay;
        end
    end

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({delay_vld_o, miss_ref_o, miss_resp_o}));                   // R11
    AST_ZERO_ON_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_edge && resp_edge && !delay_vld_o && !miss_ref_o && !miss_resp_o
         && !$isunknown(pair_delay) && pair_delay == '0 && deliver)
        |=> (delay_vld_o && delay_o == '0));                                  // R4
    AST_REF_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_ref_evt && !miss_clr_i && miss_ref_cnt_o != MISS_MAX)
        |=> (miss_ref_o && miss_ref_cnt_o == $past(miss_ref_cnt_o) + MISS_ONE)); // R6
    AST_RESP_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_resp_evt && !miss_clr_i && miss_resp_cnt_o != MISS_MAX)
        |=> (miss_resp_o && miss_resp_cnt_o == $past(miss_resp_cnt_o) + MISS_ONE)); // R7
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_vld_o && !deliver) |=> !delay_vld_o);                          // R3

endmodule

// File: tb/test_edge_delay_meter.sv
// Directed bench: one task per scenario, inputs driven on the falling edge,
// outputs checked one falling edge later (after the sampling rising edge).
module test_edge_delay_meter;

    localparam int TS_W   = 8;
    localparam int MISS_W = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ref_i = 1'b0;
    logic              resp_i = 1'b0;
    logic [1:0]        ref_pol_i = 2'b00;
    logic [1:0]        resp_pol_i = 2'b00;
    logic              miss_clr_i = 1'b0;
    logic [TS_W-1:0]   delay_o;
    logic              delay_vld_o;
    logic              miss_ref_o;
    logic              miss_resp_o;
    logic [MISS_W-1:0] miss_ref_cnt_o;
    logic [MISS_W-1:0] miss_resp_cnt_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    edge_delay_meter #(.TS_W(TS_W), .MISS_W(MISS_W)) i_edge_delay_meter (
        .clk             (clk),
        .rst_n           (rst_n),
        .ref_i           (ref_i),
        .resp_i          (resp_i),
        .ref_pol_i       (ref_pol_i),
        .resp_pol_i      (resp_pol_i),
        .miss_clr_i      (miss_clr_i),
        .delay_o         (delay_o),
        .delay_vld_o     (delay_vld_o),
        .miss_ref_o      (miss_ref_o),
        .miss_resp_o     (miss_resp_o),
        .miss_ref_cnt_o  (miss_ref_cnt_o),
        .miss_resp_cnt_o (miss_resp_cnt_o)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One sample: drive on the falling edge, result visible at the next one.
    task automatic tick(input logic r, input logic s);
        ref_i  = r;
        resp_i = s;
        @(negedge clk);
    endtask

    task automatic reset_dut(input logic r);
        rst_n  = 1'b0;
        ref_i  = r;
        resp_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        reset_dut(1'b0);
        check("R1", "delay_vld_o", delay_vld_o, 0);
        check("R1", "delay_o", delay_o, 0);
        check("R1", "miss_ref_o", miss_ref_o, 0);
        check("R1", "miss_resp_o", miss_resp_o, 0);
        check("R1", "miss_ref_cnt_o", miss_ref_cnt_o, 0);
        check("R1", "miss_resp_cnt_o", miss_resp_cnt_o, 0);
    endtask

    task automatic t_first_resp_ignored();
        tick(0, 1);
        check("R7", "miss_resp_o before first pair", miss_resp_o, 0);
        check("R7", "miss_resp_cnt_o before first pair", miss_resp_cnt_o, 0);
        check("R7", "delay_vld_o on lone response", delay_vld_o, 0);
        tick(0, 0);
    endtask

    task automatic t_prev_cleared();
        reset_dut(1'b1);          // ref held high through reset
        tick(1, 0);               // prev is 0, so this is a rising edge
        tick(1, 1);
        check("R1", "pair after high-in-reset: vld", delay_vld_o, 1);
        check("R1", "pair after high-in-reset: delay", delay_o, 1);
        tick(0, 0);
    endtask

    task automatic t_basic_delay();
        tick(1, 0);
        for (int i = 0; i < 3; i++) tick(1, 0);
        tick(1, 1);
        check("R3", "basic vld", delay_vld_o, 1);
        check("R3", "basic delay", delay_o, 4);
        check("R11", "no miss with delivery", miss_ref_o | miss_resp_o, 0);
        tick(1, 1);
        check("R3", "strobe single cycle", delay_vld_o, 0);
        tick(0, 0);
    endtask

    task automatic t_zero_delay();
        tick(1, 1);
        check("R4", "coincident vld", delay_vld_o, 1);
        check("R4", "coincident delay", delay_o, 0);
        tick(0, 0);
        tick(0, 0);
        check("R4", "back to waiting, no miss", miss_ref_o | miss_resp_o | delay_vld_o, 0);
    endtask

    task automatic t_both_while_pending();
        tick(1, 0);
        tick(0, 0);
        tick(1, 1);
        check("R5", "pending delay delivered", delay_o, 2);
        check("R5", "vld", delay_vld_o, 1);
        check("R5", "no missed reference", miss_ref_o, 0);
        tick(0, 0);
        tick(0, 1);
        check("R5", "re-armed delay", delay_o, 2);
        check("R5", "re-armed vld", delay_vld_o, 1);
        tick(0, 0);
    endtask

    task automatic t_missed_ref();
        tick(1, 0);
        tick(0, 0);
        tick(1, 0);
        check("R6", "miss_ref_o pulse", miss_ref_o, 1);
        check("R6", "miss_ref_cnt_o", miss_ref_cnt_o, 1);
        check("R11", "no vld with miss", delay_vld_o, 0);
        tick(0, 0);
        check("R6", "miss_ref_o one cycle", miss_ref_o, 0);
        tick(0, 1);
        check("R6", "delay from first reference", delay_o, 4);
        tick(0, 0);
    endtask

    task automatic t_missed_resp();
        tick(0, 1);
        check("R7", "miss_resp_o pulse", miss_resp_o, 1);
        check("R7", "miss_resp_cnt_o", miss_resp_cnt_o, 1);
        check("R11", "no vld with miss", delay_vld_o, 0);
        tick(0, 0);
    endtask

    task automatic t_polarity();
        ref_pol_i  = 2'b01;       // falling
        resp_pol_i = 2'b10;       // both
        tick(1, 0);
        check("R2", "rise ignored on falling select", delay_vld_o | miss_resp_o, 0);
        tick(0, 0);               // falling reference edge
        tick(0, 0);
        tick(0, 1);
        check("R2", "falling ref to rising resp delay", delay_o, 2);
        check("R2", "vld", delay_vld_o, 1);
        tick(0, 0);               // falling response, both-edge select
        check("R2", "falling resp counted with both-edge select", miss_resp_o, 1);
        ref_pol_i = 2'b11;        // disabled
        tick(1, 0);
        tick(0, 0);
        tick(0, 1);
        check("R2", "disabled ref never armed", miss_resp_o, 1);
        check("R2", "no delay with disabled ref", delay_vld_o, 0);
        check("R7", "miss_resp_cnt_o", miss_resp_cnt_o, 3);
        ref_pol_i  = 2'b00;
        resp_pol_i = 2'b00;
        tick(0, 0);
    endtask

    task automatic t_saturate_and_clear();
        tick(1, 0);
        for (int i = 0; i < 8; i++) begin
            tick(0, 0);
            tick(1, 0);
            check("R9", "pulse while counting or saturated", miss_ref_o, 1);
        end
        check("R9", "miss_ref_cnt_o saturated", miss_ref_cnt_o, 7);
        miss_clr_i = 1'b1;
        tick(0, 0);
        check("R10", "ref count cleared", miss_ref_cnt_o, 0);
        check("R10", "resp count cleared", miss_resp_cnt_o, 0);
        tick(1, 0);               // miss together with clear
        check("R10", "pulse with clear", miss_ref_o, 1);
        check("R10", "clear wins over increment", miss_ref_cnt_o, 0);
        miss_clr_i = 1'b0;
        tick(0, 0);
        tick(1, 0);
        check("R10", "counting resumes", miss_ref_cnt_o, 1);
        tick(0, 1);
        check("R6", "pair completes after misses", delay_vld_o, 1);
        tick(0, 0);
    endtask

    task automatic t_wrap();
        reset_dut(1'b0);
        for (int i = 0; i < 200; i++) tick(0, 0);
        tick(1, 0);
        for (int i = 0; i < 99; i++) tick(1, 0);
        tick(1, 1);
        check("R8", "delay across timestamp wrap", delay_o, 100);
        check("R8", "vld", delay_vld_o, 1);
        tick(0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_state();
        t_first_resp_ignored();
        t_prev_cleared();
        t_basic_delay();
        t_zero_delay();
        t_both_while_pending();
        t_missed_ref();
        t_missed_resp();
        t_polarity();
        t_saturate_and_clear();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule